// File: doc/BRIEF.md
# Decade Counter with Gated Clear and Load-Nine

A synchronous BCD counter whose wrap point is fixed by a parameter. With `MODULUS` of 10 it is a plain decade counter; with a smaller value from 2 to 9 it is a truncated counter that leaves the last state for zero, as if the state one past the last had been decoded onto the clear inputs, but the forbidden state is never shown. With a value from 11 to 20 a second digit is built, and the count runs through two BCD digits up to `MODULUS-1` before it returns to zero.

Two pairs of gated controls force the state. The clear pair acts only when both of its inputs are high. The load-nine pair acts only when both of its inputs are high, and it outranks the clear pair. Both pairs are sampled at the clock edge ahead of counting. A count enable gates advancing. A terminal-count flag marks the cycle that follows a wrap caused by the modulus.

Top module: `decade_counter`

## Requirements
- R1: While `rst_n` is low, `units`, `tens` and `tc` are all 0, and this takes effect without waiting for a clock edge.
- R2: At a clock edge where `clr_a` and `clr_b` are both 1 and `nine_a`/`nine_b` are not both 1, the count becomes 0 (`units`=0000, `tens`=0000) whatever `en` is, and `tc` is 0 after that edge.
- R3: At a clock edge where `nine_a` and `nine_b` are both 1, `units` becomes 1001 and `tens` 0000, whatever the clear inputs and `en` are, and `tc` is 0 after that edge.
- R4: A pair with only one input high has no effect: the counter behaves as if that pair were all low.
- R5: With `en`=1 and no forced load, each edge advances the count by one in BCD from 0 up to `MODULUS-1`, and the edge after `MODULUS-1` returns it to 0; when `MODULUS` exceeds 10, `tens` advances on the edge where `units` goes from 9 to 0. For `MODULUS` up to 10, `tens` is always 0000.
- R6: With `en`=0 and no forced load, the count keeps its value and `tc` is 0.
- R7: `tc` is 1 for exactly the one cycle after an edge where the count went from `MODULUS-1` to 0 under `en`; at every other time it is 0.
- R8: When a load has left the count at nine and `MODULUS` is below 10, the next enabled edge takes it to 0 with `tc` left at 0.
- R9: After either forced load, enabled counting continues from the loaded value (from nine, the next value is 10 when `MODULUS` exceeds 10).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Count enable |
| clr_a | input | 1 | Clear pair, first input |
| clr_b | input | 1 | Clear pair, second input |
| nine_a | input | 1 | Load-nine pair, first input |
| nine_b | input | 1 | Load-nine pair, second input |
| units | output | 4 | Low BCD digit |
| tens | output | 4 | High BCD digit (0 when `MODULUS` is 10 or less) |
| tc | output | 1 | Terminal-count flag after a modulus wrap |

## Verification
The two functions that collide are the clear and the load-nine: both pairs can be fully high at one edge, and either can also arrive while `en` is high so that a count step competes with it. The bench drives rows with all four control inputs high and `en` high, and with only one input of each pair high, against nineteen copies of the block, one per modulus from 2 to 20. A reference model built from the requirements judges each copy every cycle: the full-pair collision must leave nine with no flag, and the half-pair rows must count as if the controls were idle.

// File: rtl/dcnt_pkg.sv
package dcnt_pkg;
  localparam int DIG_W = 4;
  typedef logic [DIG_W-1:0] digit_t;
  localparam digit_t DIG_ZERO = digit_t'(0);
  localparam digit_t DIG_NINE = digit_t'(9);

  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_COUNT = 2'd1,
    ACT_CLEAR = 2'd2,
    ACT_NINE  = 2'd3
  } action_e;
endpackage

// File: rtl/dcnt_ctrl.sv
module dcnt_ctrl
  import dcnt_pkg::*;
(
  input  logic    en,
  input  logic    clr_a,
  input  logic    clr_b,
  input  logic    nine_a,
  input  logic    nine_b,
  output action_e act
);
  logic clr_full;
  logic nine_full;

  assign clr_full  = clr_a & clr_b;
  assign nine_full = nine_a & nine_b;

  // Load-nine outranks clear, both outrank counting.
  always_comb begin
    if (nine_full)     act = ACT_NINE;
    else if (clr_full) act = ACT_CLEAR;
    else if (en)       act = ACT_COUNT;
    else               act = ACT_HOLD;
  end
endmodule

// File: rtl/dcnt_digit.sv
module dcnt_digit
  import dcnt_pkg::*;
(
  input  digit_t cur,
  input  logic   inc,
  output digit_t nxt,
  output logic   carry
);
  logic at_top;

  assign at_top = (cur >= DIG_NINE);

  always_comb begin
    if (!inc)       nxt = cur;
    else if (at_top) nxt = DIG_ZERO;
    else            nxt = cur + digit_t'(1);
  end

  assign carry = inc & at_top;
endmodule

// File: rtl/dcnt_wrap.sv
module dcnt_wrap
  import dcnt_pkg::*;
#(
  parameter int MODULUS = 20
) (
  input  digit_t units,
  input  digit_t tens,
  output logic   last
);
  localparam int     LAST_VAL = MODULUS - 1;
  localparam digit_t LAST_U   = digit_t'(LAST_VAL % 10);
  localparam digit_t LAST_T   = digit_t'(LAST_VAL / 10);

  assign last = (units == LAST_U) && (tens == LAST_T);
endmodule

// File: rtl/decade_counter.sv
module decade_counter
  import dcnt_pkg::*;
#(
  parameter int MODULUS = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       clr_a,
  input  logic       clr_b,
  input  logic       nine_a,
  input  logic       nine_b,
  output logic [3:0] units,
  output logic [3:0] tens,
  output logic       tc
);
  localparam int NDIG = (MODULUS > 10) ? 2 : 1;

  action_e act;
  logic    last;
  logic    step;
  digit_t  dig_q   [NDIG];
  digit_t  dig_nxt [NDIG];
  digit_t  dig_d   [NDIG];
  logic [NDIG:0] cy;
  logic    tc_d;

  dcnt_ctrl u_ctrl (
    .en     (en),
    .clr_a  (clr_a),
    .clr_b  (clr_b),
    .nine_a (nine_a),
    .nine_b (nine_b),
    .act    (act)
  );

  dcnt_wrap #(.MODULUS(MODULUS)) u_wrap (
    .units (units),
    .tens  (tens),
    .last  (last)
  );

  // Digits advance only when the modulus decode does not claim the edge.
  assign step  = (act == ACT_COUNT) && !last;
  assign cy[0] = step;

  for (genvar g = 0; g < NDIG; g++) begin : g_dig
    dcnt_digit u_digit (
      .cur   (dig_q[g]),
      .inc   (cy[g]),
      .nxt   (dig_nxt[g]),
      .carry (cy[g+1])
    );
  end

  assign units = dig_q[0];
  if (NDIG == 2) begin : g_two
    assign tens = dig_q[1];
  end else begin : g_one
    assign tens = DIG_ZERO;
  end

  // Next-state selection.
  always_comb begin
    tc_d = 1'b0;
    for (int i = 0; i < NDIG; i++) begin
      unique case (act)
        ACT_NINE:  dig_d[i] = (i == 0) ? DIG_NINE : DIG_ZERO;
        ACT_CLEAR: dig_d[i] = DIG_ZERO;
        ACT_COUNT: begin
          if (last || cy[NDIG]) dig_d[i] = DIG_ZERO;
          else                  dig_d[i] = dig_nxt[i];
        end
        default:   dig_d[i] = dig_q[i];
      endcase
    end
    if (act == ACT_COUNT && last) tc_d = 1'b1;
  end

  // State registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NDIG; i++) dig_q[i] <= DIG_ZERO;
      tc <= 1'b0;
    end else begin
      for (int i = 0; i < NDIG; i++) dig_q[i] <= dig_d[i];
      tc <= tc_d;
    end
  end
endmodule

// File: rtl/decade_counter_chk.sv
module decade_counter_chk #(
  parameter int MODULUS = 20
) (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic       clr_a,
  input logic       clr_b,
  input logic       nine_a,
  input logic       nine_b,
  input logic [3:0] units,
  input logic [3:0] tens,
  input logic       tc
);
  localparam logic [3:0] TOP_T = 4'((MODULUS - 1) / 10);

  a_r3_nine_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (nine_a && nine_b) |=> (units == 4'd9 && tens == 4'd0 && !tc));

  a_r2_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_a && clr_b && !(nine_a && nine_b)) |=> (units == 4'd0 && tens == 4'd0 && !tc));

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !(clr_a && clr_b) && !(nine_a && nine_b))
      |=> ($stable(units) && $stable(tens) && !tc));

  a_r7_tc_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    tc |-> (units == 4'd0 && tens == 4'd0));

  a_r7_tc_single: assert property (@(posedge clk) disable iff (!rst_n)
    tc |=> !tc);

  a_r7_tc_from_count: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tc) |-> $past(en));

  a_r5_digit_range: assert property (@(posedge clk) disable iff (!rst_n)
    (units <= 4'd9) && (tens <= TOP_T));
endmodule

bind decade_counter decade_counter_chk #(.MODULUS(MODULUS)) u_chk (.*);

// File: tb/tb_decade_counter.sv
module tb_decade_counter;
  localparam int CLK_P = 10;
  localparam int NVEC  = 11;
  // [12:5] cycles, [4] en, [3] clr_a, [2] clr_b, [1] nine_a, [0] nine_b
  localparam logic [12:0] VEC [NVEC] = '{
    {8'd45, 5'b10000},
    {8'd3,  5'b00000},
    {8'd4,  5'b11010},
    {8'd1,  5'b11111},
    {8'd12, 5'b10000},
    {8'd2,  5'b10110},
    {8'd23, 5'b10000},
    {8'd1,  5'b00011},
    {8'd3,  5'b10101},
    {8'd1,  5'b01100},
    {8'd30, 5'b10000}
  };

  logic clk, rst_n, en, clr_a, clr_b, nine_a, nine_b;
  logic [3:0] act_u [2:20];
  logic [3:0] act_t [2:20];
  logic       act_c [2:20];
  logic [3:0] exp_u [2:20];
  logic [3:0] exp_t [2:20];
  logic       exp_c [2:20];
  int errors = 0;
  int checks = 0;
  string cur_req;

  for (genvar m = 2; m <= 20; m++) begin : g_m
    logic [3:0] ou, ot, mu, mt;
    logic       oc, mc;
    int         v;

    decade_counter #(.MODULUS(m)) dut (
      .clk(clk), .rst_n(rst_n), .en(en),
      .clr_a(clr_a), .clr_b(clr_b), .nine_a(nine_a), .nine_b(nine_b),
      .units(ou), .tens(ot), .tc(oc)
    );

    always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mu <= 0; mt <= 0; mc <= 0;
      end else if (nine_a && nine_b) begin
        mu <= 9; mt <= 0; mc <= 0;
      end else if (clr_a && clr_b) begin
        mu <= 0; mt <= 0; mc <= 0;
      end else if (en) begin
        v = mt * 10 + mu;
        if (v == m - 1) begin
          mu <= 0; mt <= 0; mc <= 1;
        end else if (mu == 9) begin
          mu <= 0; mt <= (m > 10) ? mt + 4'd1 : 4'd0; mc <= 0;
        end else begin
          mu <= mu + 4'd1; mc <= 0;
        end
      end else begin
        mc <= 0;
      end
    end

    assign act_u[m] = ou;
    assign act_t[m] = ot;
    assign act_c[m] = oc;
    assign exp_u[m] = mu;
    assign exp_t[m] = mt;
    assign exp_c[m] = mc;
  end

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic chk(string req, int m, logic [8:0] act, logic [8:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s mod=%0d actual tc/tens/units=%b expected=%b", req, m, act, expv);
    end
  endtask

  task automatic check_all();
    for (int m = 2; m <= 20; m++)
      chk(cur_req, m, {act_c[m], act_t[m], act_u[m]}, {exp_c[m], exp_t[m], exp_u[m]});
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    check_all();
  endtask

  task automatic drive(logic [4:0] f);
    {en, clr_a, clr_b, nine_a, nine_b} = f;
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    drive(5'b00000);
    repeat (2) @(negedge clk);
    // R1: reset state on every copy
    for (int m = 2; m <= 20; m++)
      chk("R1", m, {act_c[m], act_t[m], act_u[m]}, 9'd0);
    rst_n = 1'b1;

    for (int k = 0; k < NVEC; k++) begin
      logic [4:0] f;
      f = VEC[k][4:0];
      drive(f);
      if (f[1] && f[0])      cur_req = "R3";
      else if (f[3] && f[2]) cur_req = "R2";
      else if (!f[4])        cur_req = "R6";
      else if (f[3] || f[2] || f[1] || f[0]) cur_req = "R4";
      else                   cur_req = "R5 R7 R8 R9";
      for (int c = 0; c < int'(VEC[k][12:5]); c++) step();
    end

    // R1: asynchronous reset in mid-run
    drive(5'b10000);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    for (int m = 2; m <= 20; m++)
      chk("R1", m, {act_c[m], act_t[m], act_u[m]}, 9'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // Directed: mod-20 copy runs to 19, then wraps
    cur_req = "R5";
    repeat (19) step();
    chk("R5", 20, {act_c[20], act_t[20], act_u[20]}, {1'b0, 4'd1, 4'd9});
    step();
    chk("R7", 20, {act_c[20], act_t[20], act_u[20]}, {1'b1, 4'd0, 4'd0});
    drive(5'b00000);
    cur_req = "R7";
    step();
    chk("R7", 20, {act_c[20], act_t[20], act_u[20]}, 9'd0);

    // Directed: both pairs high, load-nine wins
    drive(5'b11111);
    cur_req = "R3";
    step();
    chk("R3", 20, {act_c[20], act_t[20], act_u[20]}, {1'b0, 4'd0, 4'd9});
    chk("R3", 6,  {act_c[6],  act_t[6],  act_u[6]},  {1'b0, 4'd0, 4'd9});

    // Directed: resume after nine
    drive(5'b10000);
    cur_req = "R9";
    step();
    chk("R9", 20, {act_c[20], act_t[20], act_u[20]}, {1'b0, 4'd1, 4'd0});
    chk("R8", 6,  {act_c[6],  act_t[6],  act_u[6]},  9'd0);

    // Directed: clear, then resume from zero
    drive(5'b01100);
    cur_req = "R2";
    step();
    chk("R2", 20, {act_c[20], act_t[20], act_u[20]}, 9'd0);
    drive(5'b10000);
    cur_req = "R9";
    step();
    chk("R9", 20, {act_c[20], act_t[20], act_u[20]}, {1'b0, 4'd0, 4'd1});
    chk("R9", 2,  {act_c[2],  act_t[2],  act_u[2]},  {1'b0, 4'd0, 4'd1});
    step();
    chk("R7", 2,  {act_c[2],  act_t[2],  act_u[2]},  {1'b1, 4'd0, 4'd0});

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule